// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records when an external event happens relative to a 16-bit timer. It watches a single capture pin. When the pin makes the chosen transition, the block copies the timer count it is given into a capture register. The same event sets a sticky capture flag, and that flag raises an interrupt request when interrupts are enabled. The counter is outside this block; the unit only samples the count it receives. The block does no noise filtering.

The capture register also serves as the counter's TOP limit in some waveform modes. While the TOP-mode input is high, the pin is disconnected from the capture logic. In that mode the register can be loaded only through a bus write port, and it keeps its value when the mode changes. All inputs and outputs are plain level or strobe signals. There is no valid/ready stream, because nothing at this edge can apply back-pressure: a capture always completes, and a bus write always completes in the cycle it is presented.

Top module: `timer_capture_unit`

## Requirements
- R1: When the selected edge appears on `cap_pin` while `top_mode` is 0, `cap_value` takes the value `count` holds at the third rising clock edge after the pin changes. Two of those edges are synchronizer stages and one is the capture itself.
- R2: `edge_rise`=1 selects the low-to-high transition and `edge_rise`=0 selects the high-to-low transition. The other transition leaves `cap_value` and `cap_flag` unchanged.
- R3: Every capture sets `cap_flag` in the same cycle that `cap_value` updates.
- R4: `irq` is high exactly when `cap_flag` and `irq_en` are both 1.
- R5: While `top_mode` is 1, transitions on `cap_pin` change neither `cap_value` nor `cap_flag`.
- R6: A `wr_en` pulse loads `wr_data` into `cap_value` at the next clock edge, but only while `top_mode` is 1. Otherwise the write has no effect.
- R7: `cap_flag` stays set until a `flag_clr` pulse clears it at the next edge. If a capture occurs in the same cycle as `flag_clr`, the flag stays set.
- R8: Reset (`rst_n` low) clears `cap_value` to 0 and `cap_flag` to 0, and sets the pin synchronizer to a low level.
- R9: `cap_value` keeps its contents when `top_mode` switches in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| edge_rise | input | 1 | 1 = capture on rising edge, 0 = falling |
| irq_en | input | 1 | Capture interrupt enable |
| top_mode | input | 1 | Capture register is in use as counter TOP |
| count | input | 16 | Current timer count |
| flag_clr | input | 1 | Clear strobe for the capture flag |
| wr_en | input | 1 | Bus write strobe for the capture register |
| wr_data | input | 16 | Bus write data |
| cap_value | output | 16 | Capture register contents |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
Each fault shows at the ports within a known number of cycles:
- A wrong synchronizer or previous-level register shifts the capture by whole cycles, or produces a capture on the wrong polarity. Because the count changes between events, a capture in the wrong cycle shows as a wrong value three edges after the pin toggles.
- A wrong flag state shows on `cap_flag` and `irq` at the next sample after the event or the clear strobe.
- A leak of pin events or writes across the TOP-mode gate shows as a changed `cap_value` right after the offending stimulus.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/icu_edge.sv
module icu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise_evt,
  output logic fall_evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise_evt = level & ~prev;
  assign fall_evt = ~level & prev;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt})); // R2
endmodule

// File: rtl/icu_capreg.sv
module icu_capreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [WIDTH-1:0] count,
  input  logic             top_mode,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             flag_clr,
  output logic [WIDTH-1:0] value,
  output logic             flag
);
  logic wr_take;
  assign wr_take = wr_en & top_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (cap_evt) begin
      value <= count;
    end else if (wr_take) begin
      value <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (cap_evt)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (value == $past(count))); // R1
  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !flag); // R7
  AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode && !wr_en) |=> $stable(value)); // R5
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_mode && !cap_evt) |=> $stable(value)); // R6
endmodule

// File: rtl/timer_capture_unit.sv
module timer_capture_unit #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic             edge_rise,
  input  logic             irq_en,
  input  logic             top_mode,
  input  logic [WIDTH-1:0] count,
  input  logic             flag_clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  import icu_pkg::*;

  logic      pin_sync;
  logic      rise_evt;
  logic      fall_evt;
  logic      cap_evt;
  edge_sel_e sel;

  assign sel = edge_sel_e'(edge_rise);

  icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cap_pin),
    .q     (pin_sync)
  );

  icu_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (pin_sync),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  always_comb begin
    cap_evt = 1'b0;
    if (!top_mode) begin
      case (sel)
        EDGE_RISE: cap_evt = rise_evt;
        default:   cap_evt = fall_evt;
      endcase
    end
  end

  icu_capreg #(.WIDTH(WIDTH)) u_capreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_evt  (cap_evt),
    .count    (count),
    .top_mode (top_mode),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_clr (flag_clr),
    .value    (cap_value),
    .flag     (cap_flag)
  );

  assign irq = cap_flag & irq_en;

  AST_NO_CAPTURE_IN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode |-> !cap_evt); // R5
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R4
endmodule

// File: tb/tb_timer_capture_unit.sv
module tb_timer_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_pin, edge_rise, irq_en, top_mode, flag_clr, wr_en;
  logic [15:0] count, wr_data;
  logic [15:0] cap_value;
  logic        cap_flag, irq;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_val;
  logic        exp_flag;

  always #5 clk = ~clk;

  timer_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_rise(edge_rise),
    .irq_en(irq_en), .top_mode(top_mode), .count(count), .flag_clr(flag_clr),
    .wr_en(wr_en), .wr_data(wr_data), .cap_value(cap_value),
    .cap_flag(cap_flag), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, {16'h0, cap_value}, {16'h0, exp_val});
    check(req, {31'h0, cap_flag}, {31'h0, exp_flag});
    check("R4", {31'h0, irq}, {31'h0, exp_flag & irq_en});
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    exp_flag = 1'b0;
    check("R7", {31'h0, cap_flag}, 32'h0);
  endtask

  // drive pin to v at a falling edge, sample after three rising edges
  task automatic move_pin(logic v, logic [15:0] cnt);
    logic old;
    @(negedge clk);
    old = cap_pin;
    cap_pin = v;
    count = cnt;
    repeat (3) @(negedge clk);
    if (!top_mode && old != v && (v == edge_rise)) begin
      exp_val  = cnt;
      exp_flag = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_pin = 1'b0; edge_rise = 1'b0; irq_en = 1'b0;
    top_mode = 1'b0; flag_clr = 1'b0; wr_en = 1'b0;
    count = 16'hBEEF; wr_data = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_val = 16'h0; exp_flag = 1'b0;
    check_all("R8");

    // sweep: polarity x mode x enable x transition direction
    for (int i = 0; i < 8; i++) begin
      edge_rise = i[0]; top_mode = i[1]; irq_en = i[2];
      for (int d = 0; d < 2; d++) begin
        move_pin(d == 0 ? ~cap_pin : ~cap_pin, 16'(16'h1357 + i * 16'd911 + d * 16'd77));
        if (top_mode) check_all("R5");
        else          check_all("R2");
        if (exp_flag) begin
          check("R3", {31'h0, cap_flag}, 32'h1);
          check("R1", {16'h0, cap_value}, {16'h0, exp_val});
        end
        clear_flag();
      end
    end

    // flag held without clear
    top_mode = 1'b0; edge_rise = 1'b1; irq_en = 1'b1;
    if (cap_pin) move_pin(1'b0, 16'h0001);
    move_pin(1'b1, 16'h4242);
    repeat (5) @(negedge clk);
    check_all("R7");

    // clear and capture in the same cycle: capture wins
    edge_rise = 1'b0;
    @(negedge clk) cap_pin = 1'b0; count = 16'h7A7A;
    @(negedge clk);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    exp_val = 16'h7A7A; exp_flag = 1'b1;
    check_all("R7");
    clear_flag();

    // write ignored outside TOP mode
    @(negedge clk) wr_en = 1'b1; wr_data = 16'hDEAD;
    @(negedge clk) wr_en = 1'b0;
    check_all("R6");

    // write in TOP mode, then mode changes keep value
    top_mode = 1'b1;
    @(negedge clk) wr_en = 1'b1; wr_data = 16'hC0DE;
    @(negedge clk) wr_en = 1'b0;
    exp_val = 16'hC0DE;
    check_all("R6");
    move_pin(1'b1, 16'h1111);
    move_pin(1'b0, 16'h2222);
    check_all("R5");
    @(negedge clk) top_mode = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R9");
    @(negedge clk) top_mode = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule